// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors work side by side. The local component keeps a short outcome history for each branch, selected by PC, and uses that history to pick a 3-bit saturating counter. The global component uses one shift register that holds the outcomes of all recently resolved branches, and uses it to pick a 2-bit saturating counter. A table of 2-bit chooser states, indexed by the global history, decides which component supplies the final answer. The chooser learns only from the branches on which the two components disagreed.

The fetch stage presents a PC on the lookup channel. In the same cycle the block returns the final direction, both component guesses and the chooser's selection. When the branch resolves, the pipeline sends back the branch PC, the real outcome and the two component guesses it captured at lookup. The block then trains every structure on the clock edge that accepts the resolve beat. Both channels use valid/ready, but the block never applies back-pressure: `lk_ready` and `rs_ready` are held high, so a beat is accepted on every cycle in which its valid is high. Lookups read state combinationally. Resolves write on the clock edge. The block does not repair history after a misprediction, predict targets, or stall.

Top module: `tournament_predictor`

## Requirements
- R1: After reset every local counter is 3 (weakly not-taken on a 0..7 scale), every global counter is 1 (weakly not-taken on 0..3), every chooser state is 1 (weakly local), and all histories are zero. A lookup then reports `pr_local`=0, `pr_global`=0, `pr_use_global`=0 and `pr_taken`=0.
- R2: The local guess is bit 2 of the 3-bit counter selected by the branch's local history. The counter goes up by one on a taken resolve and down by one on a not-taken resolve.
- R3: Local histories are 10 bits wide, one per entry, and the entry is selected by PC bits [7:2]. PCs that differ only outside these bits share an entry. A resolve shifts its outcome into bit 0 of the entry for `rs_pc`.
- R4: The 12-bit global history shifts every accepted resolve outcome into bit 0. It does not change in a cycle with no resolve.
- R5: The global guess is bit 1 of the 2-bit counter indexed by the current global history. That counter goes up on taken and down on not-taken.
- R6: The chooser entry indexed by the current global history selects the global guess when its state is 2 or 3, and the local guess when its state is 0 or 1. `pr_taken` equals the selected guess, and `pr_use_global` shows which one was selected.
- R7: On a resolve, the chooser entry indexed by the current global history changes only if `rs_local_pred` differs from `rs_global_pred`. It goes up by one when the global guess matched the outcome and down by one when the local guess matched.
- R8: Every resolve trains the local counter, the local history, the global counter and the global history, whichever component the chooser selected.
- R9: Every counter and chooser state saturates at its ends and never wraps around.
- R10: When a lookup and a resolve occur in the same cycle, the lookup outputs reflect the state before that resolve.
- R11: `lk_ready` and `rs_ready` are always 1, and `pr_valid` equals `lk_valid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup accepted (always 1) |
| lk_pc | input | PC_W | Fetch PC to predict |
| pr_valid | output | 1 | Prediction valid, same cycle as lookup |
| pr_taken | output | 1 | Final predicted direction |
| pr_local | output | 1 | Local component guess |
| pr_global | output | 1 | Global component guess |
| pr_use_global | output | 1 | Chooser selected the global component |
| rs_valid | input | 1 | Resolve beat valid |
| rs_ready | output | 1 | Resolve accepted (always 1) |
| rs_pc | input | PC_W | PC of the resolved branch |
| rs_taken | input | 1 | Actual outcome |
| rs_local_pred | input | 1 | Local guess captured at lookup |
| rs_global_pred | input | 1 | Global guess captured at lookup |

## Verification
A lookup and a resolve can fall in the same cycle, even for the same PC. In that case the lookup must see the tables and histories as they were before the training write. The bench provokes this by driving both channels in one cycle, sampling the lookup outputs before the clock edge, and comparing them with a model that has not yet applied the resolve. It then looks up again after the edge and compares the result with the updated model.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef enum logic [1:0] {
    CH_STRONG_LOCAL  = 2'd0,
    CH_WEAK_LOCAL    = 2'd1,
    CH_WEAK_GLOBAL   = 2'd2,
    CH_STRONG_GLOBAL = 2'd3
  } ch_state_e;

  // Next chooser state: moves only on disagreement, toward the correct side.
  function automatic logic [1:0] chooser_step(input logic [1:0] s,
                                              input logic lp,
                                              input logic gp,
                                              input logic t);
    logic [1:0] n;
    n = s;
    if (lp != gp) begin
      if (gp == t) begin
        if (s != CH_STRONG_GLOBAL) n = s + 2'd1;
      end else begin
        if (s != CH_STRONG_LOCAL) n = s - 2'd1;
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/tp_local_path.sv
module tp_local_path #(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 10,
  parameter int CTR_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_pred,
  input  logic             rs_valid,
  input  logic [IDX_W-1:0] rs_idx,
  input  logic             rs_taken
);
  localparam int HT_N = 1 << IDX_W;
  localparam int PT_N = 1 << HIST_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_MAX >> 1;

  logic [HIST_W-1:0] hist_q [HT_N];
  logic [CTR_W-1:0]  ctr_q  [PT_N];

  logic [HIST_W-1:0] rs_hist;
  logic [CTR_W-1:0]  rs_ctr;
  logic [CTR_W-1:0]  rs_ctr_nxt;

  assign lk_pred = ctr_q[hist_q[lk_idx]][CTR_W-1];
  assign rs_hist = hist_q[rs_idx];
  assign rs_ctr  = ctr_q[rs_hist];

  always_comb begin
    rs_ctr_nxt = rs_ctr;
    if (rs_taken && rs_ctr != CTR_MAX)           rs_ctr_nxt = rs_ctr + 1'b1;
    else if (!rs_taken && rs_ctr != '0)          rs_ctr_nxt = rs_ctr - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HT_N; i++) hist_q[i] <= '0;
      for (int j = 0; j < PT_N; j++) ctr_q[j]  <= CTR_INIT;
    end else if (rs_valid) begin
      hist_q[rs_idx] <= {rs_hist[HIST_W-2:0], rs_taken};
      ctr_q[rs_hist] <= rs_ctr_nxt;
    end
  end

  AST_LHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> hist_q[$past(rs_idx)][0] == $past(rs_taken)); // R3

  AST_LCTR_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken && rs_ctr == CTR_MAX) |=> ctr_q[$past(rs_hist)] == CTR_MAX); // R9

  AST_LCTR_SAT_BOT: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_taken && rs_ctr == '0) |=> ctr_q[$past(rs_hist)] == '0); // R9

endmodule

// File: rtl/tp_global_path.sv
module tp_global_path #(
  parameter int HIST_W = 12,
  parameter int CTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rs_valid,
  input  logic              rs_taken,
  output logic [HIST_W-1:0] ghist,
  output logic              lk_pred
);
  localparam int PT_N = 1 << HIST_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_MAX >> 1;

  logic [HIST_W-1:0] ghist_q;
  logic [CTR_W-1:0]  ctr_q [PT_N];
  logic [CTR_W-1:0]  cur;
  logic [CTR_W-1:0]  nxt;

  assign ghist   = ghist_q;
  assign cur     = ctr_q[ghist_q];
  assign lk_pred = cur[CTR_W-1];

  always_comb begin
    nxt = cur;
    if (rs_taken && cur != CTR_MAX)       nxt = cur + 1'b1;
    else if (!rs_taken && cur != '0)      nxt = cur - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghist_q <= '0;
      for (int i = 0; i < PT_N; i++) ctr_q[i] <= CTR_INIT;
    end else if (rs_valid) begin
      ghist_q        <= {ghist_q[HIST_W-2:0], rs_taken};
      ctr_q[ghist_q] <= nxt;
    end
  end

  AST_GHR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> ghist_q == {$past(ghist_q[HIST_W-2:0]), $past(rs_taken)}); // R4

  AST_GHR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> $stable(ghist_q)); // R4

endmodule

// File: rtl/tp_chooser.sv
module tp_chooser #(
  parameter int HIST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] ghist,
  input  logic              rs_valid,
  input  logic              rs_taken,
  input  logic              rs_lp,
  input  logic              rs_gp,
  output logic              use_global
);
  import tp_pkg::*;

  localparam int CT_N = 1 << HIST_W;

  logic [1:0] st_q [CT_N];
  logic [1:0] cur;

  assign cur        = st_q[ghist];
  assign use_global = cur[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CT_N; i++) st_q[i] <= CH_WEAK_LOCAL;
    end else if (rs_valid) begin
      st_q[ghist] <= chooser_step(cur, rs_lp, rs_gp, rs_taken);
    end
  end

  AST_CH_AGREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_lp == rs_gp) |=> st_q[$past(ghist)] == $past(cur)); // R7

  AST_CH_SAT_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_lp != rs_gp && rs_gp == rs_taken && cur == 2'd3)
      |=> st_q[$past(ghist)] == 2'd3); // R9

  AST_CH_SAT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_lp != rs_gp && rs_lp == rs_taken && cur == 2'd0)
      |=> st_q[$past(ghist)] == 2'd0); // R9

endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor #(
  parameter int PC_W    = 32,
  parameter int LIDX_W  = 6,
  parameter int LHIST_W = 10,
  parameter int LCTR_W  = 3,
  parameter int GHIST_W = 12,
  parameter int GCTR_W  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  output logic            lk_ready,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pr_valid,
  output logic            pr_taken,
  output logic            pr_local,
  output logic            pr_global,
  output logic            pr_use_global,
  input  logic            rs_valid,
  output logic            rs_ready,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic            rs_local_pred,
  input  logic            rs_global_pred
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + LIDX_W - 1;

  logic [LIDX_W-1:0]  lk_idx;
  logic [LIDX_W-1:0]  rs_idx;
  logic [GHIST_W-1:0] ghist;
  logic               rs_fire;
  logic               unused_pc_bits;

  assign lk_ready = 1'b1;
  assign rs_ready = 1'b1;
  assign rs_fire  = rs_valid && rs_ready;
  assign lk_idx   = lk_pc[IDX_HI:IDX_LO];
  assign rs_idx   = rs_pc[IDX_HI:IDX_LO];
  assign unused_pc_bits = ^{lk_pc[PC_W-1:IDX_HI+1], lk_pc[IDX_LO-1:0],
                            rs_pc[PC_W-1:IDX_HI+1], rs_pc[IDX_LO-1:0]};

  tp_local_path #(.IDX_W(LIDX_W), .HIST_W(LHIST_W), .CTR_W(LCTR_W)) u_local (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (lk_idx),
    .lk_pred  (pr_local),
    .rs_valid (rs_fire),
    .rs_idx   (rs_idx),
    .rs_taken (rs_taken)
  );

  tp_global_path #(.HIST_W(GHIST_W), .CTR_W(GCTR_W)) u_global (
    .clk      (clk),
    .rst_n    (rst_n),
    .rs_valid (rs_fire),
    .rs_taken (rs_taken),
    .ghist    (ghist),
    .lk_pred  (pr_global)
  );

  tp_chooser #(.HIST_W(GHIST_W)) u_chooser (
    .clk        (clk),
    .rst_n      (rst_n),
    .ghist      (ghist),
    .rs_valid   (rs_fire),
    .rs_taken   (rs_taken),
    .rs_lp      (rs_local_pred),
    .rs_gp      (rs_global_pred),
    .use_global (pr_use_global)
  );

  assign pr_valid = lk_valid;
  assign pr_taken = pr_use_global ? pr_global : pr_local;

  AST_AGREE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && pr_local == pr_global) |-> pr_taken == pr_global); // R6

endmodule

// File: tb/tb_tournament_predictor.sv
`timescale 1ns/1ps
module tb_tournament_predictor;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            lk_valid;
  logic            lk_ready;
  logic [PC_W-1:0] lk_pc;
  logic            pr_valid, pr_taken, pr_local, pr_global, pr_use_global;
  logic            rs_valid;
  logic            rs_ready;
  logic [PC_W-1:0] rs_pc;
  logic            rs_taken, rs_local_pred, rs_global_pred;

  int n_checks = 0;
  int n_fail   = 0;

  // Reference state built from the requirements.
  int m_lh [64];
  int m_lc [1024];
  int m_gc [4096];
  int m_ch [4096];
  int m_ghr;

  always #4 clk = ~clk;

  tournament_predictor dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc),
    .pr_valid(pr_valid), .pr_taken(pr_taken), .pr_local(pr_local),
    .pr_global(pr_global), .pr_use_global(pr_use_global),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_pc(rs_pc),
    .rs_taken(rs_taken), .rs_local_pred(rs_local_pred),
    .rs_global_pred(rs_global_pred)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++)   m_lh[i] = 0;
    for (int i = 0; i < 1024; i++) m_lc[i] = 3;
    for (int i = 0; i < 4096; i++) begin m_gc[i] = 1; m_ch[i] = 1; end
    m_ghr = 0;
  endtask

  task automatic model_update(input logic [PC_W-1:0] pc, input logic t,
                              input logic lp, input logic gp);
    int ix = int'(pc[7:2]);
    int h  = m_lh[ix];
    if (t) begin
      if (m_lc[h] < 7) m_lc[h]++;
      if (m_gc[m_ghr] < 3) m_gc[m_ghr]++;
    end else begin
      if (m_lc[h] > 0) m_lc[h]--;
      if (m_gc[m_ghr] > 0) m_gc[m_ghr]--;
    end
    if (lp != gp) begin
      if (gp == t) begin if (m_ch[m_ghr] < 3) m_ch[m_ghr]++; end
      else         begin if (m_ch[m_ghr] > 0) m_ch[m_ghr]--; end
    end
    m_lh[ix] = ((h << 1) | int'(t)) & 32'h3FF;
    m_ghr    = ((m_ghr << 1) | int'(t)) & 32'hFFF;
  endtask

  task automatic compare_model(input string req, input logic [PC_W-1:0] pc);
    int ml = (m_lc[m_lh[int'(pc[7:2])]] >= 4) ? 1 : 0;
    int mg = (m_gc[m_ghr] >= 2) ? 1 : 0;
    int mu = (m_ch[m_ghr] >= 2) ? 1 : 0;
    check(req, "pr_local",      int'(pr_local), ml);
    check(req, "pr_global",     int'(pr_global), mg);
    check(req, "pr_use_global", int'(pr_use_global), mu);
    check(req, "pr_taken",      int'(pr_taken), mu ? mg : ml);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; lk_valid = 1'b0; lk_pc = '0;
    rs_valid = 1'b0; rs_pc = '0; rs_taken = 1'b0;
    rs_local_pred = 1'b0; rs_global_pred = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic lookup(input logic [PC_W-1:0] pc, output logic lp, output logic gp);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc;
    #1;
    lp = pr_local; gp = pr_global;
  endtask

  task automatic resolve(input logic [PC_W-1:0] pc, input logic t,
                         input logic lp, input logic gp);
    @(negedge clk);
    rs_valid = 1'b1; rs_pc = pc; rs_taken = t;
    rs_local_pred = lp; rs_global_pred = gp;
    @(posedge clk);
    #1 rs_valid = 1'b0;
    model_update(pc, t, lp, gp);
  endtask

  task automatic ghr_to_zero(input logic [PC_W-1:0] pc);
    for (int k = 0; k < 12; k++) resolve(pc, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset_state();
    logic lp, gp;
    apply_reset();
    @(negedge clk); #1;
    check("R11", "pr_valid idle", int'(pr_valid), 0);
    check("R11", "lk_ready", int'(lk_ready), 1);
    check("R11", "rs_ready", int'(rs_ready), 1);
    for (int p = 0; p < 4; p++) begin
      lookup(32'h1000 + 32'(p * 52), lp, gp);
      check("R11", "pr_valid", int'(pr_valid), 1);
      check("R1", "pr_local", int'(pr_local), 0);
      check("R1", "pr_global", int'(pr_global), 0);
      check("R1", "pr_use_global", int'(pr_use_global), 0);
      check("R1", "pr_taken", int'(pr_taken), 0);
    end
  endtask

  task automatic t_local_learn();
    logic lp, gp;
    apply_reset();
    resolve(32'h2000, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 10; k++) resolve(32'h2000, 1'b0, 1'b0, 1'b0);
    lookup(32'h2000, lp, gp);
    check("R2", "local after taken at history 0", int'(pr_local), 1);
    lookup(32'h2104, lp, gp);
    check("R3", "fresh entry shares pattern counter", int'(pr_local), 1);
    lookup(32'h7000, lp, gp);
    check("R3", "alias on PC[7:2]", int'(pr_local), 1);
    compare_model("R3", 32'h7000);
    resolve(32'h2104, 1'b1, lp, gp);
    lookup(32'h2104, lp, gp);
    check("R3", "entry history 1 counter", int'(pr_local), 0);
    compare_model("R2", 32'h2104);
    lookup(32'h2000, lp, gp);
    check("R3", "other entry untouched", int'(pr_local), 1);
  endtask

  task automatic t_chooser_global_wins();
    logic lp, gp;
    apply_reset();
    resolve(32'h3000, 1'b1, 1'b0, 1'b1);
    lookup(32'h3000, lp, gp);
    check("R6", "chooser at new history still local", int'(pr_use_global), 0);
    ghr_to_zero(32'h3000);
    lookup(32'h3000, lp, gp);
    check("R7", "chooser moved to global", int'(pr_use_global), 1);
    check("R8", "global counter trained while local selected", int'(pr_global), 1);
    check("R5", "global guess at history 0", int'(pr_global), 1);
    check("R4", "history back to 0 local guess", int'(pr_local), 0);
    check("R6", "final follows global", int'(pr_taken), 1);
    compare_model("R6", 32'h3000);
  endtask

  task automatic t_chooser_agree_hold();
    logic lp, gp;
    apply_reset();
    resolve(32'h3400, 1'b0, 1'b1, 1'b1);
    ghr_to_zero(32'h3400);
    lookup(32'h3400, lp, gp);
    check("R7", "agreeing guesses leave chooser", int'(pr_use_global), 0);
    compare_model("R7", 32'h3400);
  endtask

  task automatic t_chooser_saturate();
    logic lp, gp;
    apply_reset();
    for (int k = 0; k < 3; k++) begin
      resolve(32'h3800, 1'b0, 1'b1, 1'b0);
      ghr_to_zero(32'h3800);
    end
    lookup(32'h3800, lp, gp);
    check("R9", "chooser held at top", int'(pr_use_global), 1);
    resolve(32'h3800, 1'b1, 1'b1, 1'b0);
    ghr_to_zero(32'h3800);
    lookup(32'h3800, lp, gp);
    check("R9", "one local win from top stays global", int'(pr_use_global), 1);
    for (int k = 0; k < 4; k++) begin
      resolve(32'h3800, 1'b1, 1'b1, 1'b0);
      ghr_to_zero(32'h3800);
    end
    resolve(32'h3800, 1'b0, 1'b1, 1'b0);
    ghr_to_zero(32'h3800);
    lookup(32'h3800, lp, gp);
    check("R9", "chooser held at bottom", int'(pr_use_global), 0);
    compare_model("R9", 32'h3800);
  endtask

  task automatic t_same_cycle();
    logic lp, gp;
    apply_reset();
    for (int k = 0; k < 6; k++) resolve(32'h4000, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 8; k++) begin
      lookup(32'h4000, lp, gp);
      @(negedge clk);
      lk_pc = 32'h4000;
      rs_valid = 1'b1; rs_pc = 32'h4000; rs_taken = k[0];
      rs_local_pred = ~lp; rs_global_pred = gp;
      #1;
      compare_model("R10", 32'h4000);
      @(posedge clk);
      #1 rs_valid = 1'b0;
      model_update(32'h4000, k[0], ~lp, gp);
      lookup(32'h4000, lp, gp);
      compare_model("R10", 32'h4000);
    end
  endtask

  task automatic t_stream();
    logic lp, gp, t;
    logic [15:0] lfsr = 16'hACE1;
    logic [PC_W-1:0] pc;
    apply_reset();
    for (int n = 0; n < 1500; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pc = 32'h8000 + 32'({lfsr[2:0], 2'b00}) + 32'({lfsr[4], 8'h00});
      case (lfsr[2:0])
        3'd0, 3'd1: t = 1'b1;
        3'd2:       t = 1'b0;
        3'd3:       t = n[0];
        3'd4:       t = (n % 3) != 0;
        default:    t = lfsr[7];
      endcase
      lookup(pc, lp, gp);
      compare_model("R5", pc);
      if (lfsr[9]) begin
        @(negedge clk);
        lk_valid = 1'b0;
        #1 check("R11", "pr_valid drops with lk_valid", int'(pr_valid), 0);
      end
      resolve(pc, t, lp, gp);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_pc = '0;
    rs_valid = 1'b0; rs_pc = '0; rs_taken = 1'b0;
    rs_local_pred = 1'b0; rs_global_pred = 1'b0;
    t_reset_state();
    t_local_learn();
    t_chooser_global_wins();
    t_chooser_agree_hold();
    t_chooser_saturate();
    t_same_cycle();
    t_stream();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule